// File: doc/BRIEF.md
# Bus Controller Run-Control Sequencer

This block is the run-control state machine of a command/response serial bus controller that walks lists of message instructions. Software writes one-shot strobes to run, halt, kill or divert the controller. Message traffic, line coding and instruction fetch sit outside the block. They appear here only as strobes: a message has ended, a return-from-async instruction has executed, a flag was stored, a loopback check failed.

The block holds the current list pointer. It can branch into a separate asynchronous list when the current message ends, and it returns to the interrupted main list with the pointer restored exactly. It composes an 8-bit status word. It also runs a response-timeout timer that counts microsecond ticks derived from the system clock. The timer raises a one-cycle no-response pulse unless a reply starts first.

Top module: `bcrun_seq`

## Requirements
- R1: A start write (control bit 0) while idle, with the status async bit (bit 2) at 0, sets `active` and loads `list_ptr` with `list_base` on the next cycle. It also sets status bit 4 and clears status bit 5. While status bit 2 is 1, a start write leaves `active` and `list_ptr` unchanged.
- R2: A stop write (control bit 1) while running keeps `active` at 1 until the next `msg_done`. `active` is 0 in the cycle after that strobe.
- R3: An abort write (control bit 2) clears `active` and status bit 2 on the next cycle. Abort wins over stop written in the same cycle. A stop that is pending when abort arrives is discarded.
- R4: An async write (control bit 3) sets status bit 2 at once. While running, the branch happens at the next `msg_done`: `list_ptr` becomes `async_base`. A further async write during the async list is ignored.
- R5: A `ret_async` strobe during the async list restores `list_ptr` to the entry after the interrupted message and clears status bit 2.
- R6: An async write while idle branches to `async_base` one cycle after the request is registered. On return from such a list the controller goes idle again.
- R7: Each `msg_done` while running advances `list_ptr` by one.
- R8: Status layout: bit 0 active, bit 1 `bus_sel` (0 = bus A, 1 = bus B), bit 2 async requested or running, bit 3 stored flag, bit 4 frame succeeded, bit 5 loopback failure, bits 7:6 zero.
- R9: After `tmr_go`, `no_resp` pulses for exactly one cycle (12 + 4*sel) * `CLK_PER_US` cycles later. Here sel is the 2-bit response field: 00 = 12 µs, 01 = 16 µs, 10 = 20 µs, 11 = 24 µs. The field resets to 01.
- R10: A `resp_seen` strobe before expiry cancels the timeout, and no `no_resp` pulse follows.
- R11: `msg_done` with `msg_err` clears status bit 4. A `loop_fail` strobe sets status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 4 | Control bits: 0 start, 1 stop, 2 abort, 3 async |
| cfg_wr | input | 1 | Response-field write strobe |
| cfg_resp | input | 2 | Response-time select |
| list_base | input | PTR_W | Main list start address |
| async_base | input | PTR_W | Async list start address |
| msg_done | input | 1 | Current message finished |
| msg_err | input | 1 | Qualifies msg_done as failed |
| ret_async | input | 1 | Return-from-async instruction executed |
| flag_wr | input | 1 | Store-flag strobe |
| flag_in | input | 1 | Flag value to store |
| loop_fail | input | 1 | Loopback failure strobe |
| bus_sel | input | 1 | Bus in use |
| tmr_go | input | 1 | Start response timer |
| resp_seen | input | 1 | Reply has started |
| list_ptr | output | PTR_W | Current instruction pointer |
| status | output | 8 | Status word |
| no_resp | output | 1 | One-cycle timeout pulse |

## Verification
On every cycle the assertions check four things: abort leaves the controller idle with no async state, running continues until a message end or return, a start from a clean idle state is accepted, and the branch at message end lands on the async base. They also check that the timeout pulse lasts one cycle and that a reply strobe suppresses it. Only the bench scenarios show the following: exact pointer values across nested branch and return, refusal of start while an async list is stalled, discarding of a pending stop by abort, and the exact expiry cycle for every response setting.

// File: rtl/bcrun_seq.sv
module bcrun_seq #(
  parameter int PTR_W      = 16,
  parameter int CLK_PER_US = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [3:0]       ctl_wdata,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_resp,
  input  logic [PTR_W-1:0] list_base,
  input  logic [PTR_W-1:0] async_base,
  input  logic             msg_done,
  input  logic             msg_err,
  input  logic             ret_async,
  input  logic             flag_wr,
  input  logic             flag_in,
  input  logic             loop_fail,
  input  logic             bus_sel,
  input  logic             tmr_go,
  input  logic             resp_seen,
  output logic [PTR_W-1:0] list_ptr,
  output logic [7:0]       status,
  output logic             no_resp
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);

  logic active, in_async, async_pend, stop_pend, idle_entry;
  logic flag_q, frame_ok, loop_bad;
  logic [PTR_W-1:0] save_ptr;
  logic [1:0] resp_sel;
  logic running;
  logic [PW-1:0] pre;
  logic [4:0] us_cnt;
  logic [4:0] limit;

  wire start_w = ctl_wr & ctl_wdata[0];
  wire stop_w  = ctl_wr & ctl_wdata[1];
  wire abort_w = ctl_wr & ctl_wdata[2];
  wire async_w = ctl_wr & ctl_wdata[3];
  wire start_ok = start_w & ~abort_w & ~active & ~async_pend & ~in_async;
  wire ret_ok = ret_async & in_async & ~abort_w;

  assign status = {2'b00, loop_bad, frame_ok, flag_q, async_pend | in_async, bus_sel, active};
  assign limit  = 5'd12 + {1'b0, resp_sel, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      in_async   <= 1'b0;
      async_pend <= 1'b0;
      stop_pend  <= 1'b0;
      idle_entry <= 1'b0;
      list_ptr   <= '0;
      save_ptr   <= '0;
    end else if (abort_w) begin
      active     <= 1'b0;
      in_async   <= 1'b0;
      async_pend <= 1'b0;
      stop_pend  <= 1'b0;
      idle_entry <= 1'b0;
    end else if (ret_ok) begin
      list_ptr   <= save_ptr;
      in_async   <= 1'b0;
      active     <= active & ~idle_entry;
      stop_pend  <= stop_pend & ~idle_entry;
      idle_entry <= 1'b0;
    end else if (!active) begin
      if (async_pend && !in_async) begin
        save_ptr   <= list_ptr;
        list_ptr   <= async_base;
        in_async   <= 1'b1;
        async_pend <= 1'b0;
        active     <= 1'b1;
        idle_entry <= 1'b1;
      end else if (start_ok) begin
        active   <= 1'b1;
        list_ptr <= list_base;
      end
      if (async_w && !in_async && !async_pend) async_pend <= 1'b1;
    end else begin
      if (stop_w) stop_pend <= 1'b1;
      if (async_w && !in_async && !async_pend) async_pend <= 1'b1;
      if (msg_done) begin
        list_ptr <= list_ptr + 1'b1;
        if (stop_pend) begin
          active    <= 1'b0;
          stop_pend <= 1'b0;
        end else if (async_pend && !in_async) begin
          save_ptr   <= list_ptr + 1'b1;
          list_ptr   <= async_base;
          in_async   <= 1'b1;
          async_pend <= 1'b0;
          idle_entry <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      frame_ok <= 1'b0;
      loop_bad <= 1'b0;
      resp_sel <= 2'b01;
    end else begin
      if (flag_wr) flag_q <= flag_in;
      if (cfg_wr) resp_sel <= cfg_resp;
      if (start_ok) begin
        frame_ok <= 1'b1;
        loop_bad <= 1'b0;
      end else begin
        if (active && msg_done && msg_err) frame_ok <= 1'b0;
        if (loop_fail) loop_bad <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pre     <= '0;
      us_cnt  <= '0;
      no_resp <= 1'b0;
    end else begin
      no_resp <= 1'b0;
      if (tmr_go) begin
        running <= 1'b1;
        pre     <= '0;
        us_cnt  <= '0;
      end else if (resp_seen || abort_w) begin
        running <= 1'b0;
      end else if (running) begin
        if (pre == PRE_LAST) begin
          pre <= '0;
          if (us_cnt == limit - 5'd1) begin
            no_resp <= 1'b1;
            running <= 1'b0;
          end else begin
            us_cnt <= us_cnt + 5'd1;
          end
        end else begin
          pre <= pre + 1'b1;
        end
      end
    end
  end

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> (!status[0] && !status[2])); // R3
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !msg_done && !ret_async && !abort_w) |=> status[0]); // R2
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_w && !abort_w && !status[0] && !status[2]) |=> (status[0] && list_ptr == $past(list_base))); // R1
  AST_BRANCH_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && msg_done && async_pend && !in_async && !stop_pend && !abort_w && !ret_async)
      |=> (list_ptr == $past(async_base) && status[2])); // R4
  AST_RET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ok |=> !status[2]); // R5
  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    no_resp |=> !no_resp); // R9
  AST_REPLY_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_seen && !tmr_go) |=> !no_resp); // R10
endmodule

// File: tb/sim_bcrun_seq.sv
`timescale 1ns/1ps
module sim_bcrun_seq;
  localparam int PTR_W = 16;
  localparam int CPU   = 10;
  localparam logic [15:0] LB = 16'h0100;
  localparam logic [15:0] AB = 16'h0800;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_wr = 0, cfg_wr = 0, msg_done = 0, msg_err = 0, ret_async = 0;
  logic flag_wr = 0, flag_in = 0, loop_fail = 0, bus_sel = 0, tmr_go = 0, resp_seen = 0;
  logic [3:0] ctl_wdata = '0;
  logic [1:0] cfg_resp = '0;
  logic [PTR_W-1:0] list_ptr;
  logic [7:0] status;
  logic no_resp;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bcrun_seq #(.PTR_W(PTR_W), .CLK_PER_US(CPU)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .cfg_wr(cfg_wr), .cfg_resp(cfg_resp), .list_base(LB), .async_base(AB),
    .msg_done(msg_done), .msg_err(msg_err), .ret_async(ret_async),
    .flag_wr(flag_wr), .flag_in(flag_in), .loop_fail(loop_fail), .bus_sel(bus_sel),
    .tmr_go(tmr_go), .resp_seen(resp_seen), .list_ptr(list_ptr), .status(status),
    .no_resp(no_resp));

  // timeout table: {write cfg?, sel, expected cycles}
  localparam logic [11:0] TV [5] = '{
    {1'b0, 2'b01, 9'd160}, {1'b1, 2'b00, 9'd120}, {1'b1, 2'b10, 9'd200},
    {1'b1, 2'b11, 9'd240}, {1'b1, 2'b01, 9'd160}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [3:0] b);
    @(negedge clk); ctl_wr = 1; ctl_wdata = b;
    @(negedge clk); ctl_wr = 0; ctl_wdata = '0;
  endtask

  task automatic done_msg(input logic err);
    @(negedge clk); msg_done = 1; msg_err = err;
    @(negedge clk); msg_done = 0; msg_err = 0;
  endtask

  task automatic ret();
    @(negedge clk); ret_async = 1;
    @(negedge clk); ret_async = 0;
  endtask

  task automatic time_out(input string req, input int exp);
    int n = 0;
    int seen = -1;
    @(negedge clk); tmr_go = 1;
    @(negedge clk); tmr_go = 0;
    for (int k = 1; k <= 300; k++) begin
      @(negedge clk);
      if (no_resp && seen < 0) seen = k;
      if (no_resp) n++;
    end
    chk(req, seen, exp);
    chk(req, n, 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 reset status", status, 8'h00);
    chk("R7 reset ptr", list_ptr, 0);
    chk("R9 reset no_resp", no_resp, 0);

    ctl(4'b0001);
    chk("R1 start status", status, 8'h11);
    chk("R1 start ptr", list_ptr, LB);
    done_msg(0); done_msg(0);
    chk("R7 advance", list_ptr, LB + 2);

    ctl(4'b1000);
    chk("R4 async pending bit", status, 8'h15);
    chk("R4 no branch before end", list_ptr, LB + 2);
    done_msg(0);
    chk("R4 branch ptr", list_ptr, AB);
    ctl(4'b1000);
    done_msg(0);
    chk("R7 async advance", list_ptr, AB + 1);
    ret();
    chk("R5 restore ptr", list_ptr, LB + 3);
    chk("R5 async cleared (second request ignored, R4)", status, 8'h11);

    ctl(4'b0010);
    chk("R2 stop waits", status[0], 1);
    done_msg(0);
    chk("R2 stopped", status, 8'h10);
    chk("R2 ptr", list_ptr, LB + 4);

    ctl(4'b0001);
    ctl(4'b1000);
    done_msg(0);
    ctl(4'b0010);
    done_msg(0);
    chk("R1 stalled async status", status, 8'h14);
    ctl(4'b0001);
    chk("R1 start refused status", status, 8'h14);
    chk("R1 start refused ptr", list_ptr, AB + 1);
    ctl(4'b0100);
    chk("R3 abort clears async", status, 8'h10);

    ctl(4'b0001);
    ctl(4'b0010);
    done_msg(0);
    chk("R2 idle ptr", list_ptr, LB + 1);
    ctl(4'b1000);
    chk("R6 request registered idle", status, 8'h14);
    @(negedge clk);
    chk("R6 idle branch", status, 8'h15);
    chk("R6 idle branch ptr", list_ptr, AB);
    done_msg(0);
    ret();
    chk("R6 return to idle", status, 8'h10);
    chk("R5 idle return ptr", list_ptr, LB + 1);

    ctl(4'b0001);
    ctl(4'b0110);
    chk("R3 abort beats stop", status[0], 0);
    ctl(4'b0001);
    ctl(4'b0010);
    ctl(4'b0100);
    ctl(4'b0001);
    done_msg(0);
    chk("R3 pending stop discarded", status[0], 1);
    chk("R3 ptr", list_ptr, LB + 1);
    ctl(4'b1000);
    ctl(4'b0100);
    chk("R3 abort cancels request", status, 8'h10);

    ctl(4'b0001);
    @(negedge clk); loop_fail = 1;
    @(negedge clk); loop_fail = 0;
    done_msg(1);
    chk("R11 frame fail and loopback", status, 8'h21);
    @(negedge clk); flag_wr = 1; flag_in = 1; bus_sel = 1;
    @(negedge clk); flag_wr = 0; flag_in = 0;
    chk("R8 flag and bus bits", status, 8'h2B);
    ctl(4'b0100);

    foreach (TV[i]) begin
      if (TV[i][11]) begin
        @(negedge clk); cfg_wr = 1; cfg_resp = TV[i][10:9];
        @(negedge clk); cfg_wr = 0;
      end
      time_out("R9 timeout", int'(TV[i][8:0]));
    end

    @(negedge clk); tmr_go = 1;
    @(negedge clk); tmr_go = 0;
    repeat (50) @(negedge clk);
    resp_seen = 1;
    @(negedge clk); resp_seen = 0;
    begin
      int hits = 0;
      for (int k = 0; k < 300; k++) begin
        @(negedge clk);
        if (no_resp) hits++;
      end
      chk("R10 reply cancels", hits, 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule